// File: doc/BRIEF.md
# Load/Store Effective Address and Byte-Lane Unit

This unit sits between the execute and data-cache stages of a 64-bit in-order pipeline. For each memory operation it adds a base register value to a sign-extended 16-bit displacement to form the effective address. It then works out which of the eight byte lanes of the addressed doubleword the access covers. Lane selection depends on the access size, the three low address bits and a configuration bit that selects big- or little-endian ordering.

The address always names the lowest-order byte of the accessed field. The unit also reports the byte shift that moves the field down to lane zero. An access that is not naturally aligned is never split. It raises an address-error request instead, with separate load and store flavours so that downstream logic can choose the right exception code, and all byte enables are held low. All results are registered, so they appear one clock after the request.

Top module: `ls_lane_unit`

## Requirements
- R1: `ea_o` equals `base_i` plus `imm_i` sign-extended to 64 bits, with wraparound modulo 2^64. It appears together with `valid_o`, exactly one clock after `valid_i` is sampled high.
- R2: The size code on `size_i` means 0 = byte, 1 = halfword (2 bytes), 2 = word (4 bytes) and 3 = doubleword (8 bytes). An access is permitted only when the offset o = `ea_o[2:0]` is a multiple of its byte count, and a permitted access enables exactly that many lanes.
- R3: In little-endian mode (`big_endian_i` = 0), a permitted access of n bytes at offset o sets `be_o` bits o through o+n-1 and no others.
- R4: In big-endian mode (`big_endian_i` = 1), the byte at distance k from the addressed byte sits on `be_o` bit 7-o-k, for k from 0 to n-1.
- R5: For a permitted access, `shift_o` holds the index of the lowest set bit of `be_o`.
- R6: A misaligned access raises `adel_o` when `store_i` is 0 and `ades_o` when `store_i` is 1. The two are never high together.
- R7: Whenever `adel_o` or `ades_o` is high, `be_o` and `shift_o` are zero.
- R8: A clock with `valid_i` low gives `valid_o` low, `be_o` zero and both error outputs low on the next clock, whatever the other inputs hold.
- R9: While `rst_n` is low, `valid_o`, `ea_o`, `be_o`, `shift_o`, `adel_o` and `ades_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Memory operation present this cycle |
| base_i | input | 64 | Base register value |
| imm_i | input | 16 | Signed displacement |
| size_i | input | 2 | Access size code |
| big_endian_i | input | 1 | 1 selects big-endian lane order |
| store_i | input | 1 | 1 for store, 0 for load |
| valid_o | output | 1 | Result valid |
| ea_o | output | 64 | Effective address |
| be_o | output | 8 | Byte-lane enables for the doubleword |
| shift_o | output | 3 | Byte shift to lane zero |
| adel_o | output | 1 | Address-error request, load |
| ades_o | output | 1 | Address-error request, store |

## Verification
Address formation and the alignment decision happen in the same cycle. The alignment test has to use the low bits of the sum, not those of the base. The bench provokes this in two ways: a misaligned base whose displacement carries it onto an aligned word, which must not trap, and an aligned base pushed off alignment by a negative or odd displacement, which must trap. In each case the bench compares the enables, the shift and both error flags against values worked out by hand from the summed address.

// File: rtl/ls_lane_unit.sv
module ls_lane_unit #(
  parameter int XLEN  = 64,
  parameter int IMM_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [63:0]     base_i,
  input  logic [15:0]     imm_i,
  input  logic [1:0]      size_i,
  input  logic            big_endian_i,
  input  logic            store_i,
  output logic            valid_o,
  output logic [63:0]     ea_o,
  output logic [7:0]      be_o,
  output logic [2:0]      shift_o,
  output logic            adel_o,
  output logic            ades_o
);
  localparam int LANES = XLEN / 8;
  localparam int OFS_W = $clog2(LANES);

  logic [XLEN-1:0]  ea;
  logic [OFS_W-1:0] ofs;
  logic [OFS_W:0]   nbytes;
  logic [OFS_W:0]   lo;
  logic [LANES-1:0] field;
  logic [LANES-1:0] mask;
  logic             misalign;

  assign ea       = base_i + {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  assign ofs      = ea[OFS_W-1:0];
  assign nbytes   = (OFS_W+1)'(1) << size_i;
  assign misalign = (ofs & OFS_W'(nbytes - 1'b1)) != '0;

  for (genvar i = 0; i < LANES; i++) begin : g_field
    assign field[i] = (OFS_W+1)'(i) < nbytes;
  end

  assign lo   = big_endian_i ? (OFS_W+1)'(LANES) - {1'b0, ofs} - nbytes
                             : {1'b0, ofs};
  assign mask = field << lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      ea_o    <= '0;
      be_o    <= '0;
      shift_o <= '0;
      adel_o  <= 1'b0;
      ades_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      ea_o    <= ea;
      be_o    <= (valid_i && !misalign) ? mask : '0;
      shift_o <= (valid_i && !misalign) ? lo[OFS_W-1:0] : '0;
      adel_o  <= valid_i && misalign && !store_i;
      ades_o  <= valid_i && misalign && store_i;
    end
  end
endmodule

module ls_lane_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        valid_i,
  input logic        big_endian_i,
  input logic        valid_o,
  input logic [63:0] ea_o,
  input logic [7:0]  be_o,
  input logic [2:0]  shift_o,
  input logic        adel_o,
  input logic        ades_o
);
  logic armed;
  logic big_d;
  logic err;

  assign err = adel_o || ades_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      big_d <= 1'b0;
    end else begin
      armed <= 1'b1;
      big_d <= big_endian_i;
    end
  end

  // R1
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (valid_o == $past(valid_i)));

  // R2
  lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !err) |-> ($countones(be_o) inside {1, 2, 4, 8}));

  // R3
  le_anchor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && valid_o && !err && !big_d) |-> be_o[ea_o[2:0]]);

  // R4
  be_anchor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && valid_o && !err && big_d) |-> be_o[3'd7 - ea_o[2:0]]);

  // R5
  shift_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !err) |-> (be_o[shift_o] && (shift_o == 3'd0 || !be_o[shift_o - 3'd1])));

  // R6
  err_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(adel_o && ades_o));

  // R7
  err_clears_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (be_o == 8'h00 && shift_o == 3'd0));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (be_o == 8'h00 && !adel_o && !ades_o));
endmodule

bind ls_lane_unit ls_lane_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .big_endian_i(big_endian_i),
  .valid_o(valid_o), .ea_o(ea_o), .be_o(be_o), .shift_o(shift_o),
  .adel_o(adel_o), .ades_o(ades_o)
);

// File: tb/tb_ls_lane_unit.sv
module tb_ls_lane_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] base_i = '0;
  logic [15:0] imm_i = '0;
  logic [1:0]  size_i = '0;
  logic        big_endian_i = 1'b0;
  logic        store_i = 1'b0;
  logic        valid_o;
  logic [63:0] ea_o;
  logic [7:0]  be_o;
  logic [2:0]  shift_o;
  logic        adel_o;
  logic        ades_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ls_lane_unit dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .base_i(base_i), .imm_i(imm_i),
    .size_i(size_i), .big_endian_i(big_endian_i), .store_i(store_i),
    .valid_o(valid_o), .ea_o(ea_o), .be_o(be_o), .shift_o(shift_o),
    .adel_o(adel_o), .ades_o(ades_o)
  );

  typedef struct packed {
    logic [63:0] base;
    logic [15:0] imm;
    logic [1:0]  sz;
    logic        big;
    logic        st;
    logic [7:0]  be;
    logic [2:0]  sh;
    logic        adel;
    logic        ades;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [0:NV-1] = '{
    '{64'h1000, 16'h0000, 2'd0, 1'b0, 1'b0, 8'h01, 3'd0, 1'b0, 1'b0},
    '{64'h1000, 16'h0005, 2'd0, 1'b0, 1'b0, 8'h20, 3'd5, 1'b0, 1'b0},
    '{64'h1000, 16'h0005, 2'd0, 1'b1, 1'b0, 8'h04, 3'd2, 1'b0, 1'b0},
    '{64'h1002, 16'h0004, 2'd1, 1'b0, 1'b1, 8'hC0, 3'd6, 1'b0, 1'b0},
    '{64'h1002, 16'h0004, 2'd1, 1'b1, 1'b1, 8'h03, 3'd0, 1'b0, 1'b0},
    '{64'h2000, 16'h0004, 2'd2, 1'b0, 1'b0, 8'hF0, 3'd4, 1'b0, 1'b0},
    '{64'h2000, 16'h0004, 2'd2, 1'b1, 1'b0, 8'h0F, 3'd0, 1'b0, 1'b0},
    '{64'h2000, 16'h0000, 2'd2, 1'b1, 1'b0, 8'hF0, 3'd4, 1'b0, 1'b0},
    '{64'h2000, 16'h0000, 2'd3, 1'b0, 1'b1, 8'hFF, 3'd0, 1'b0, 1'b0},
    '{64'h2000, 16'h0003, 2'd1, 1'b0, 1'b0, 8'h00, 3'd0, 1'b1, 1'b0},
    '{64'h2000, 16'h0002, 2'd2, 1'b1, 1'b1, 8'h00, 3'd0, 1'b0, 1'b1},
    '{64'h2000, 16'h0004, 2'd3, 1'b0, 1'b1, 8'h00, 3'd0, 1'b0, 1'b1},
    '{64'h1008, 16'hFFFF, 2'd0, 1'b0, 1'b0, 8'h80, 3'd7, 1'b0, 1'b0},
    '{64'h1000, 16'hFFFE, 2'd1, 1'b1, 1'b0, 8'h03, 3'd0, 1'b0, 1'b0},
    '{64'h0000, 16'h8000, 2'd3, 1'b1, 1'b0, 8'hFF, 3'd0, 1'b0, 1'b0},
    '{64'h0FFF, 16'h0001, 2'd2, 1'b0, 1'b1, 8'h0F, 3'd0, 1'b0, 1'b0},
    '{64'h1004, 16'h0001, 2'd3, 1'b1, 1'b0, 8'h00, 3'd0, 1'b1, 1'b0}
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] exp_ea;
    // R9: reset state, with a misaligned request present on the inputs
    valid_i = 1'b1; base_i = 64'h3; imm_i = 16'h0; size_i = 2'd2; store_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R9", "valid_o", 64'(valid_o), 64'd0);
    check("R9", "ea_o", ea_o, 64'd0);
    check("R9", "be_o", 64'(be_o), 64'd0);
    check("R9", "shift_o", 64'(shift_o), 64'd0);
    check("R9", "err", 64'({adel_o, ades_o}), 64'd0);
    valid_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1..R7: table walk
    for (int i = 0; i < NV; i++) begin
      valid_i      = 1'b1;
      base_i       = TBL[i].base;
      imm_i        = TBL[i].imm;
      size_i       = TBL[i].sz;
      big_endian_i = TBL[i].big;
      store_i      = TBL[i].st;
      exp_ea       = TBL[i].base + {{48{TBL[i].imm[15]}}, TBL[i].imm};
      @(negedge clk);
      check("R1", "valid_o", 64'(valid_o), 64'd1);
      check("R1", "ea_o", ea_o, exp_ea);
      check(TBL[i].big ? "R4" : "R3", "be_o", 64'(be_o), 64'(TBL[i].be));
      check("R5", "shift_o", 64'(shift_o), 64'(TBL[i].sh));
      check("R6", "adel_o", 64'(adel_o), 64'(TBL[i].adel));
      check("R6", "ades_o", 64'(ades_o), 64'(TBL[i].ades));
      if (TBL[i].adel || TBL[i].ades)
        check("R7", "be_o on error", 64'(be_o), 64'd0);
      else
        check("R2", "lane count", 64'($countones(be_o)), 64'(1 << TBL[i].sz));
    end

    // R8: idle cycle with misaligned store inputs
    valid_i = 1'b0; base_i = 64'h1001; imm_i = 16'h0; size_i = 2'd3; store_i = 1'b1;
    @(negedge clk);
    check("R8", "valid_o", 64'(valid_o), 64'd0);
    check("R8", "be_o", 64'(be_o), 64'd0);
    check("R8", "err", 64'({adel_o, ades_o}), 64'd0);

    // R1: request directly after idle gets one-clock latency
    valid_i = 1'b1; base_i = 64'h40; imm_i = 16'h0006; size_i = 2'd1; big_endian_i = 1'b0; store_i = 1'b0;
    @(negedge clk);
    valid_i = 1'b0;
    check("R1", "valid_o after idle", 64'(valid_o), 64'd1);
    check("R3", "be_o after idle", 64'(be_o), 64'hC0);
    @(negedge clk);
    check("R8", "valid_o drops", 64'(valid_o), 64'd0);

    // R9: reset mid-stream clears outputs
    valid_i = 1'b1; base_i = 64'h2000; imm_i = 16'h0; size_i = 2'd3;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9", "valid_o in reset", 64'(valid_o), 64'd0);
    check("R9", "be_o in reset", 64'(be_o), 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule